// File: doc/BRIEF.md
# Two-Class Interrupt Pending Controller

This block gathers interrupt requests from eighteen peripheral sources and turns each rising edge on a request line into a sticky pending flag. Each flag is steered, under software control, to one of two active-low request lines toward the processor core. One line is for the normal class (IRQ). The other is for the fast class (FIQ), which the core treats as higher priority. Because a flag stays set until software explicitly clears it, requests that arrive while the core is busy with another handler of the same class are held for later service.

Software reaches two registers over a plain register bus. That bus has an address, write data, a write strobe, and read data that is combinational from the address. The class register holds one bit per source, where 1 selects FIQ. In the pending register, writing 0 to a bit clears it and writing 1 leaves it unchanged. With this convention a handler can acknowledge exactly one source without a read-modify-write race against new arrivals. The bus carries single-cycle register accesses with no back-pressure, so it has no valid/ready handshake. Every pin is a plain control or status pin.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, both registers read 0 and both `irq_n` and `fiq_n` are high.
- R2: A 0-to-1 change on `src_req[i]`, sampled at a clock edge, sets pending bit i at that edge. A request held high does not set the bit again once it has been cleared.
- R3: A write to the pending register at offset 0xC004 clears every bit i where `bus_wdata[i]` is 0 and leaves every bit where `bus_wdata[i]` is 1 unchanged.
- R4: If a new rising edge on source i coincides with a write that clears bit i, the bit ends up set.
- R5: The class register at offset 0xC000 reads back the last value written to bits 17..0. Bit i = 1 routes source i to FIQ, and 0 routes it to IRQ.
- R6: `irq_n` is low exactly when some pending bit is set whose class bit is 0.
- R7: `fiq_n` is low exactly when some pending bit is set whose class bit is 1. A class change re-routes an already pending bit in the cycle after the write.
- R8: Read data bits 31..18 are always 0, and writes to those bits are ignored. An access to any other offset reads 0 and changes no state.
- R9: Pending bit i reflects source i in index order. Indices 0–1 are external lines, 2–4 are UART receive, transmit and error, and 5–6 are DMA channels. Indices 7–16 alternate timer overflow and match for timers 0..4, and index 17 is the basic timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 18 | Request lines, one per source, rising-edge sensitive |
| bus_addr | input | 16 | Register offset |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_n | output | 1 | Normal-class request to core, active low |
| fiq_n | output | 1 | Fast-class request to core, active low |

## Verification
The bench targets four hazards.

- A clear that coincides with a fresh edge must keep the bit set. A design that let the clear win would silently lose that interrupt.
- A source that stays high after its bit is cleared must not set the bit again. A level-sensitive design would keep the core's request line stuck low.
- Writing 1s must leave set bits alone. A design that wrote the pending register directly would fabricate requests or drop them.
- Class changes on pending bits must move the request between `irq_n` and `fiq_n`. Writes to upper bits and to unmapped offsets must leave no trace in read data.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int NUM_SRC    = 18;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 32;
  localparam logic [ADDR_W-1:0] CLASS_OFS = 16'hC000;
  localparam logic [ADDR_W-1:0] PEND_OFS  = 16'hC004;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef struct packed {
    logic class_sel;
    logic pend_sel;
  } reg_dec_t;
endpackage

// File: rtl/irqp_edge_cap.sv
module irqp_edge_cap #(
  parameter int N = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= req[g];
    end
    assign rise[g] = req[g] & ~prev_q[g];
  end

  // R2: a rise is never reported on two consecutive cycles for the same line
  a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/irqp_pend_store.sv
module irqp_pend_store #(
  parameter int N = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise,
  input  logic         clr_we,
  input  logic [N-1:0] keep_mask,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_we) pend_d = pend_d & keep_mask;
    pend_d = pend_d | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

  a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend_q & ~$past(keep_mask) & ~$past(rise)) == '0));

  a_r3_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> (($past(pend_q) & $past(keep_mask) & ~pend_q) == '0));

  a_r4_rise_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (rise & ~keep_mask) != '0) |=> ((pend_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irqp_class_route.sv
module irqp_class_route #(
  parameter int N = 18
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] fast_sel,
  output logic         irq_n,
  output logic         fiq_n
);
  logic [N-1:0] norm_hits;
  logic [N-1:0] fast_hits;

  always_comb begin
    norm_hits = pend & ~fast_sel;
    fast_hits = pend & fast_sel;
    irq_n     = ~(|norm_hits);
    fiq_n     = ~(|fast_hits);
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irqp_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter logic [AW-1:0] CLASS_ADDR = CLASS_OFS,
  parameter logic [AW-1:0] PEND_ADDR  = PEND_OFS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr_en,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq_n,
  output logic             fiq_n
);
  localparam int PAD_W = DW - N_SRC;

  reg_dec_t         dec;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] class_q;

  always_comb begin
    dec.class_sel = (bus_addr == CLASS_ADDR);
    dec.pend_sel  = (bus_addr == PEND_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        class_q <= '0;
    else if (bus_wr_en && dec.class_sel) class_q <= bus_wdata[N_SRC-1:0];
  end

  irqp_edge_cap #(.N(N_SRC)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (src_req),
    .rise (rise)
  );

  irqp_pend_store #(.N(N_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .clr_we   (bus_wr_en && dec.pend_sel),
    .keep_mask(bus_wdata[N_SRC-1:0]),
    .pend_q   (pend)
  );

  irqp_class_route #(.N(N_SRC)) u_route (
    .pend    (pend),
    .fast_sel(class_q),
    .irq_n   (irq_n),
    .fiq_n   (fiq_n)
  );

  always_comb begin
    bus_rdata = '0;
    if (dec.class_sel)     bus_rdata = {{PAD_W{1'b0}}, class_q};
    else if (dec.pend_sel) bus_rdata = {{PAD_W{1'b0}}, pend};
  end

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:N_SRC] == '0);

  a_r5_class_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && dec.class_sel) |=> $stable(class_q));

  a_r6_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (irq_n && fiq_n));

  a_r7_fast_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_n |-> (pend != '0));
endmodule

// File: tb/irq_pend_ctrl_bench.sv
module irq_pend_ctrl_bench;
  localparam logic [15:0] A_CLS = 16'hC000;
  localparam logic [15:0] A_PND = 16'hC004;
  localparam logic [15:0] A_BAD = 16'hC008;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [17:0] src_req = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr_en = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_n, fiq_n;

  int checks = 0;
  int fails  = 0;

  logic [17:0] m_prev = '0, m_pend = '0, m_cls = '0;

  irq_pend_ctrl u_irq_pend_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_n(irq_n), .fiq_n(fiq_n)
  );

  always #10 clk = ~clk;

  function automatic logic exp_irq_n(logic [17:0] p, logic [17:0] c);
    return ~(|(p & ~c));
  endfunction
  function automatic logic exp_fiq_n(logic [17:0] p, logic [17:0] c);
    return ~(|(p & c));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lines(string req);
    chk({req, " irq_n"}, {31'd0, irq_n}, {31'd0, exp_irq_n(m_pend, m_cls)});
    chk({req, " fiq_n"}, {31'd0, fiq_n}, {31'd0, exp_fiq_n(m_pend, m_cls)});
  endtask

  // called at negedge; drives, clocks, updates model, checks lines at next negedge
  task automatic cyc(logic [17:0] s, logic [15:0] a, logic w, logic [31:0] d, string req);
    logic [17:0] rise;
    src_req = s; bus_addr = a; bus_wr_en = w; bus_wdata = d;
    @(posedge clk);
    rise = s & ~m_prev;
    m_prev = s;
    if (w && a == A_PND) m_pend = m_pend & d[17:0];
    m_pend = m_pend | rise;
    if (w && a == A_CLS) m_cls = d[17:0];
    @(negedge clk);
    bus_wr_en = 0;
    lines(req);
  endtask

  task automatic rd(logic [15:0] a, string req);
    logic [31:0] e;
    bus_addr = a; bus_wr_en = 0;
    #1;
    e = (a == A_CLS) ? {14'd0, m_cls} : (a == A_PND) ? {14'd0, m_pend} : 32'd0;
    chk(req, bus_rdata, e);
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [17:0] s;
    logic [15:0] a;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(A_CLS, "R1 class reset");
    rd(A_PND, "R1 pend reset");
    lines("R1");
    // R2/R9: source 3 edge sets bit 3
    cyc(18'h00008, A_PND, 0, 0, "R2");
    rd(A_PND, "R9 bit3 position");
    chk("R2 bit3", {31'd0, bus_rdata[3]}, 32'd1);
    // R3: clear bit 3 while held high, must not re-set (R2)
    cyc(18'h00008, A_PND, 1, 32'hFFFF_FFF7, "R3");
    cyc(18'h00008, A_PND, 0, 0, "R2 level");
    rd(A_PND, "R2 held high no reset");
    // R3: writing ones keeps set bits
    cyc(18'h20009, A_PND, 0, 0, "R2");
    cyc(18'h20009, A_PND, 1, 32'hFFFF_FFFF, "R3 keep");
    rd(A_PND, "R3 ones keep");
    // R4: new edge on bit 5 with clear of bit 5
    cyc(18'h20009, A_PND, 0, 0, "R4 prep");
    cyc(18'h20029, A_PND, 1, 32'h0000_0000, "R4");
    rd(A_PND, "R4 edge beats clear");
    // R5/R7: route bit 5 to fast class
    cyc(18'h20029, A_CLS, 1, 32'h0000_0020, "R7 reroute");
    rd(A_CLS, "R5 class readback");
    // R8: upper bits and unmapped offset
    cyc(18'h20029, A_CLS, 1, 32'hFFFF_FFFF, "R8");
    rd(A_CLS, "R8 upper ignored");
    cyc(18'h20029, A_BAD, 1, 32'h0000_0000, "R8 bad");
    rd(A_BAD, "R8 unmapped reads 0");
    rd(A_PND, "R8 unmapped no effect");
    // R6: all normal class, clear all
    cyc(18'h00000, A_CLS, 1, 32'h0, "R6");
    cyc(18'h00000, A_PND, 1, 32'h0, "R6 idle");
    // random
    for (int i = 0; i < 3000; i++) begin
      s = $urandom;
      case ($urandom_range(0, 3))
        0: a = A_CLS;
        1, 2: a = A_PND;
        default: a = A_BAD;
      endcase
      cyc(s, a, ($urandom_range(0, 2) == 0), $urandom, "R6/R7 random");
      if (i % 16 == 0) begin
        rd(A_PND, "R3 random pend");
        rd(A_CLS, "R5 random class");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule